// File: doc/BRIEF.md
# Serial Memory Pause and Reset Front End

This block is the pin-facing control slice of a serial memory slave. It watches the chip-select, serial-clock, data-in and a shared pause/reset pin, and decides each cycle whether the slave is idle, selected, paused or in reset. From that decision it gives the command decoder a gated one-cycle strobe per serial-clock rising edge, enables or floats the serial output driver, issues reset and lock-clear strobes to the internal logic, and tells the power manager whether the part must stay in its active power state. A busy flag from the internal write engine is taken as an input.

All pin inputs are brought into the system clock domain through a two-flop synchronizer, and every edge and level decision is made on the synchronized copies. An elaboration parameter chooses what the shared pin does. In the pause build, a low pin freezes serial traffic while the part is selected, and entry into and exit from that state are aligned to a low serial clock. In the reset build, a low pin resets the interface. Selection is then refused for a programmable number of system-clock cycles after the pin is released.

Top module: `pause_reset_front`

## Requirements
- R1: After synchronous reset, dout_oe, shift_en, logic_reset and lock_clear are 0, and active_pwr equals engine_busy.
- R2: While selected and not paused, dout_oe is 1. Each rising edge of sck_pin produces exactly one shift_en pulse, three system-clock edges after the pin change, and shift_bit carries din_pin at that moment. Bits are taken most significant first.
- R3: In the pause build, a falling ctl_n_pin while selected starts the pause at once if sck_pin is low. If sck_pin is high, the pause starts when sck_pin next falls.
- R4: In the pause build, a rising ctl_n_pin ends the pause at once if sck_pin is low. If sck_pin is high, the pause ends when sck_pin next falls.
- R5: While paused, dout_oe is 0 and sck_pin and din_pin produce no shift_en pulse.
- R6: A ctl_n_pin fall while cs_n_pin is high does not start a pause, and a pin already low when selection begins does not pause the slave. Pause entry and exit never pulse logic_reset.
- R7: Raising cs_n_pin while paused gives exactly one logic_reset pulse. Selection is then refused until ctl_n_pin and cs_n_pin have both been high together.
- R8: active_pwr is 1 whenever the slave is selected or engine_busy is 1, and 0 otherwise.
- R9: In the reset build, a falling ctl_n_pin gives one logic_reset pulse and a rising ctl_n_pin gives one lock_clear pulse. Selection is refused while the pin is low and for RECOVERY_CYCLES cycles after its rise is seen.
- R10: In the reset build, a chip-select low seen while selection is refused is ignored until cs_n_pin goes high and falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| ctl_n_pin | input | 1 | Shared pause/reset pin, active low |
| din_pin | input | 1 | Serial data input pin |
| engine_busy | input | 1 | Internal write/program/erase cycle running |
| shift_en | output | 1 | One-cycle strobe per accepted serial-clock rise |
| shift_bit | output | 1 | Data bit that goes with shift_en |
| dout_oe | output | 1 | Serial output driver enable |
| logic_reset | output | 1 | One-cycle reset strobe to the interface logic |
| lock_clear | output | 1 | One-cycle strobe that clears all lock bits |
| active_pwr | output | 1 | Part must stay in active power mode |

## Verification
A wrong pause, pending or blocking flag shows on dout_oe within one cycle of the synchronized decision, and on shift_en at the next serial-clock rise. The bench holds a behavioural model of both builds and compares every output each clock. Any divergence is therefore reported three edges after the pin change that caused it. The deferred entry and exit cases, deselect inside a pause, and a chip select that falls during reset recovery are each driven so that a misplaced edge qualification changes dout_oe in a cycle where the model expects otherwise.

// File: rtl/prf_pkg.sv
// Shared types for the pause/reset front end.
// Assumes: pins are sampled as one packed vector in the system clock domain.
package prf_pkg;
    typedef struct packed {
        logic din;
        logic ctl_n;
        logic sck;
        logic cs_n;
    } pin_t;

    localparam pin_t PIN_IDLE = '{din: 1'b0, ctl_n: 1'b1, sck: 1'b0, cs_n: 1'b1};

    typedef enum logic {
        PIN_PAUSE = 1'b0,
        PIN_RESET = 1'b1
    } pin_fn_e;
endpackage

// File: rtl/prf_sync.sv
// Multi-stage synchronizer with one extra delayed copy for edge detection.
// Assumes: inputs are asynchronous levels; RST_VAL is the idle pin state.
module prf_sync #(
    parameter int STAGES = 2,
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [STAGES:0][W-1:0] stg;

    // Shift the pin vector through the chain, last stage is the previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q      = stg[STAGES-1];
    assign q_prev = stg[STAGES];
endmodule

// File: rtl/prf_pause_ctrl.sv
// Pause-build controller: selection, clock-low qualified pause entry/exit,
// deselect-in-pause reset and re-entry blocking.
// Assumes: cur/prv are synchronized pin vectors one cycle apart.
module prf_pause_ctrl
    import prf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pin_t cur,
    input  pin_t prv,
    output logic sel_o,
    output logic held_o,
    output logic shift_en_o,
    output logic shift_bit_o,
    output logic lreset_o
);
    logic held, pend_in, pend_out, blocked;
    logic ctl_fall, ctl_rise, sck_fall, sck_rise;

    assign ctl_fall = prv.ctl_n & ~cur.ctl_n;
    assign ctl_rise = ~prv.ctl_n & cur.ctl_n;
    assign sck_fall = prv.sck & ~cur.sck;
    assign sck_rise = ~prv.sck & cur.sck;
    assign sel_o    = ~cur.cs_n & ~blocked;
    assign held_o   = held;

    // Track pause state, pending transitions and post-deselect blocking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held        <= 1'b0;
            pend_in     <= 1'b0;
            pend_out    <= 1'b0;
            blocked     <= 1'b0;
            lreset_o    <= 1'b0;
            shift_en_o  <= 1'b0;
            shift_bit_o <= 1'b0;
        end else begin
            lreset_o    <= 1'b0;
            shift_en_o  <= sel_o & ~held & sck_rise;
            shift_bit_o <= cur.din;
            if (cur.cs_n) begin
                held     <= 1'b0;
                pend_in  <= 1'b0;
                pend_out <= 1'b0;
                if (held) begin
                    lreset_o <= 1'b1;
                    blocked  <= 1'b1;
                end else if (cur.ctl_n) begin
                    blocked <= 1'b0;
                end
            end else if (!blocked) begin
                if (!held) begin
                    if (ctl_fall) begin
                        if (!cur.sck) held    <= 1'b1;
                        else          pend_in <= 1'b1;
                    end else if (pend_in) begin
                        if (cur.ctl_n) begin
                            pend_in <= 1'b0;
                        end else if (sck_fall) begin
                            held    <= 1'b1;
                            pend_in <= 1'b0;
                        end
                    end
                end else begin
                    if (ctl_rise) begin
                        if (!cur.sck) held     <= 1'b0;
                        else          pend_out <= 1'b1;
                    end else if (pend_out) begin
                        if (!cur.ctl_n) begin
                            pend_out <= 1'b0;
                        end else if (sck_fall) begin
                            held     <= 1'b0;
                            pend_out <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prf_reset_ctrl.sv
// Reset-build controller: reset and lock-clear strobes, recovery counter,
// refusal of selection and chip-select lockout.
// Assumes: cur/prv are synchronized pin vectors one cycle apart.
module prf_reset_ctrl
    import prf_pkg::*;
#(
    parameter int RECOVERY_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  pin_t cur,
    input  pin_t prv,
    output logic sel_o,
    output logic shift_en_o,
    output logic shift_bit_o,
    output logic lreset_o,
    output logic lock_clr_o
);
    localparam int CW = $clog2(RECOVERY_CYCLES + 1) + 1;

    logic [CW-1:0] rec_cnt;
    logic          blocked, refused;

    assign refused = ~cur.ctl_n | (rec_cnt != '0);
    assign sel_o   = ~cur.cs_n & ~refused & ~blocked;

    // Strobes, recovery countdown and chip-select lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_cnt     <= '0;
            blocked     <= 1'b0;
            lreset_o    <= 1'b0;
            lock_clr_o  <= 1'b0;
            shift_en_o  <= 1'b0;
            shift_bit_o <= 1'b0;
        end else begin
            lreset_o    <= prv.ctl_n & ~cur.ctl_n;
            lock_clr_o  <= ~prv.ctl_n & cur.ctl_n;
            shift_en_o  <= sel_o & ~prv.sck & cur.sck;
            shift_bit_o <= cur.din;
            if (~prv.ctl_n & cur.ctl_n) rec_cnt <= CW'(RECOVERY_CYCLES);
            else if (rec_cnt != '0)     rec_cnt <= rec_cnt - 1'b1;
            if (cur.cs_n)     blocked <= 1'b0;
            else if (refused) blocked <= 1'b1;
        end
    end
endmodule

// File: rtl/pause_reset_front.sv
// Top of the serial memory pause/reset front end. Synchronizes the pins and
// instantiates the controller chosen by PIN_FN.
// Assumes: engine_busy is already in the clk domain.
module pause_reset_front
    import prf_pkg::*;
#(
    parameter pin_fn_e PIN_FN          = PIN_PAUSE,
    parameter int      SYNC_STAGES     = 2,
    parameter int      RECOVERY_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic ctl_n_pin,
    input  logic din_pin,
    input  logic engine_busy,
    output logic shift_en,
    output logic shift_bit,
    output logic dout_oe,
    output logic logic_reset,
    output logic lock_clear,
    output logic active_pwr
);
    localparam int PW = $bits(pin_t);

    pin_t             raw, cur, prv;
    logic [PW-1:0]    q_w, qp_w;
    logic             sel_w, held_w;

    assign raw = '{din: din_pin, ctl_n: ctl_n_pin, sck: sck_pin, cs_n: cs_n_pin};
    assign cur = pin_t'(q_w);
    assign prv = pin_t'(qp_w);

    prf_sync #(.STAGES(SYNC_STAGES), .W(PW), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(q_w), .q_prev(qp_w)
    );

    generate
        if (PIN_FN == PIN_RESET) begin : g_reset
            prf_reset_ctrl #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_ctrl (
                .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv),
                .sel_o(sel_w), .shift_en_o(shift_en), .shift_bit_o(shift_bit),
                .lreset_o(logic_reset), .lock_clr_o(lock_clear)
            );
            assign held_w = 1'b0;
        end else begin : g_pause
            prf_pause_ctrl u_ctrl (
                .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv),
                .sel_o(sel_w), .held_o(held_w), .shift_en_o(shift_en),
                .shift_bit_o(shift_bit), .lreset_o(logic_reset)
            );
            assign lock_clear = 1'b0;
        end
    endgenerate

    assign dout_oe    = sel_w & ~held_w;
    assign active_pwr = sel_w | engine_busy;
endmodule

// File: rtl/prf_checker.sv
// Property checker for pause_reset_front, attached with bind.
// Assumes: held reflects the controller's pause flag.
module prf_checker (
    input logic clk,
    input logic rst_n,
    input logic engine_busy,
    input logic held,
    input logic shift_en,
    input logic dout_oe,
    input logic logic_reset,
    input logic lock_clear,
    input logic active_pwr
);
    AST_HOLD_MUTES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) held |-> !dout_oe); // R5
    AST_HOLD_STOPS_SHIFT:  assert property (@(posedge clk) disable iff (!rst_n) held |-> !shift_en); // R5
    AST_RESET_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) logic_reset |=> !logic_reset); // R7
    AST_LOCK_ONE_CYCLE:    assert property (@(posedge clk) disable iff (!rst_n) lock_clear |=> !lock_clear); // R9
    AST_BUSY_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) engine_busy |-> active_pwr); // R8
    AST_OE_KEEPS_ACTIVE:   assert property (@(posedge clk) disable iff (!rst_n) dout_oe |-> active_pwr); // R8
endmodule

bind pause_reset_front prf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy), .held(held_w),
    .shift_en(shift_en), .dout_oe(dout_oe), .logic_reset(logic_reset),
    .lock_clear(lock_clear), .active_pwr(active_pwr)
);

// File: tb/tb_pause_reset_front.sv
module tb_pause_reset_front;
    import prf_pkg::*;

    localparam int REC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // pause-build pins
    logic h_cs = 1, h_sck = 0, h_ctl = 1, h_din = 0, h_busy = 0;
    logic h_se, h_sb, h_oe, h_lr, h_lc, h_ap;
    // reset-build pins
    logic r_cs = 1, r_sck = 0, r_ctl = 1, r_din = 0;
    logic r_se, r_sb, r_oe, r_lr, r_lc, r_ap;

    pause_reset_front #(.PIN_FN(PIN_PAUSE)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(h_cs), .sck_pin(h_sck), .ctl_n_pin(h_ctl),
        .din_pin(h_din), .engine_busy(h_busy), .shift_en(h_se), .shift_bit(h_sb),
        .dout_oe(h_oe), .logic_reset(h_lr), .lock_clear(h_lc), .active_pwr(h_ap));

    pause_reset_front #(.PIN_FN(PIN_RESET), .RECOVERY_CYCLES(REC)) dut_r (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(r_cs), .sck_pin(r_sck), .ctl_n_pin(r_ctl),
        .din_pin(r_din), .engine_busy(1'b0), .shift_en(r_se), .shift_bit(r_sb),
        .dout_oe(r_oe), .logic_reset(r_lr), .lock_clear(r_lc), .active_pwr(r_ap));

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;
    int n_shift = 0, n_lr = 0, n_lc = 0, rn_lr = 0, rn_lc = 0;
    logic [7:0] cap = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---- behavioural reference: pin history as queues, state as integers ----
    pin_t hq[$], rq[$];
    int m_held = 0, m_pin = 0, m_pout = 0, m_blk = 0;
    int e_se = 0, e_sb = 0, e_lr = 0;
    int mr_cnt = 0, mr_blk = 0;
    int er_se = 0, er_sb = 0, er_lr = 0, er_lc = 0;

    function automatic pin_t mk(logic cs, logic sck, logic ctl, logic din);
        pin_t p; p.cs_n = cs; p.sck = sck; p.ctl_n = ctl; p.din = din; return p;
    endfunction

    task automatic model_step();
        pin_t c, p;
        int oh, osel, refd;
        if (!rst_n) begin
            hq = '{PIN_IDLE, PIN_IDLE, PIN_IDLE};
            rq = '{PIN_IDLE, PIN_IDLE, PIN_IDLE};
            m_held = 0; m_pin = 0; m_pout = 0; m_blk = 0; e_se = 0; e_sb = 0; e_lr = 0;
            mr_cnt = 0; mr_blk = 0; er_se = 0; er_sb = 0; er_lr = 0; er_lc = 0;
            return;
        end
        // pause build: hq[1] is the settled view, hq[2] the one before
        c = hq[1]; p = hq[2];
        oh = m_held; osel = !c.cs_n && !m_blk;
        e_lr = 0;
        e_se = osel && !oh && !p.sck && c.sck;
        e_sb = c.din;
        if (c.cs_n) begin
            if (oh) begin e_lr = 1; m_blk = 1; end
            else if (c.ctl_n) m_blk = 0;
            m_held = 0; m_pin = 0; m_pout = 0;
        end else if (!m_blk) begin
            if (!oh) begin
                if (p.ctl_n && !c.ctl_n) begin
                    if (c.sck) m_pin = 1; else m_held = 1;
                end else if (m_pin) begin
                    if (c.ctl_n) m_pin = 0;
                    else if (p.sck && !c.sck) begin m_held = 1; m_pin = 0; end
                end
            end else begin
                if (!p.ctl_n && c.ctl_n) begin
                    if (c.sck) m_pout = 1; else m_held = 0;
                end else if (m_pout) begin
                    if (!c.ctl_n) m_pout = 0;
                    else if (p.sck && !c.sck) begin m_held = 0; m_pout = 0; end
                end
            end
        end
        void'(hq.pop_back());
        hq.push_front(mk(h_cs, h_sck, h_ctl, h_din));
        // reset build
        c = rq[1]; p = rq[2];
        refd = !c.ctl_n || mr_cnt != 0;
        er_se = (!c.cs_n && !refd && !mr_blk) && !p.sck && c.sck;
        er_sb = c.din;
        er_lr = p.ctl_n && !c.ctl_n;
        er_lc = !p.ctl_n && c.ctl_n;
        if (er_lc) mr_cnt = REC; else if (mr_cnt > 0) mr_cnt--;
        if (c.cs_n) mr_blk = 0; else if (refd) mr_blk = 1;
        void'(rq.pop_back());
        rq.push_front(mk(r_cs, r_sck, r_ctl, r_din));
    endtask

    task automatic compare();
        pin_t c;
        int e_oe, e_ap, er_oe;
        c = hq[1];
        e_oe = !c.cs_n && !m_blk && !m_held;
        e_ap = (!c.cs_n && !m_blk) || h_busy;
        c = rq[1];
        er_oe = !c.cs_n && !(!c.ctl_n || mr_cnt != 0) && !mr_blk;
        chk(h_oe == e_oe, {cur_req, " pause dout_oe"}, h_oe, e_oe);
        chk(h_se == e_se, {cur_req, " pause shift_en"}, h_se, e_se);
        if (e_se) chk(h_sb == e_sb, {cur_req, " pause shift_bit"}, h_sb, e_sb);
        chk(h_lr == e_lr, {cur_req, " pause logic_reset"}, h_lr, e_lr);
        chk(h_lc == 0, {cur_req, " pause lock_clear"}, h_lc, 0);
        chk(h_ap == e_ap, {cur_req, " pause active_pwr"}, h_ap, e_ap);
        chk(r_oe == er_oe, {cur_req, " reset dout_oe"}, r_oe, er_oe);
        chk(r_se == er_se, {cur_req, " reset shift_en"}, r_se, er_se);
        chk(r_lr == er_lr, {cur_req, " reset logic_reset"}, r_lr, er_lr);
        chk(r_lc == er_lc, {cur_req, " reset lock_clear"}, r_lc, er_lc);
        if (h_se) begin n_shift++; cap = {cap[6:0], h_sb}; end
        if (h_lr) n_lr++;
        if (h_lc) n_lc++;
        if (r_lr) rn_lr++;
        if (r_lc) rn_lc++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            model_step();
            if (rst_n) compare();
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        run(3);
        rst_n = 1;
        run(4);
        cur_req = "R1";
        chk(h_oe == 0 && h_se == 0 && h_lr == 0, "R1 idle outputs", h_oe, 0);
        chk(h_ap == 0, "R1 active_pwr follows busy", h_ap, 0);

        // R2: shift a byte
        cur_req = "R2";
        h_cs = 0; run(4);
        chk(h_oe == 1, "R2 selected dout_oe", h_oe, 1);
        pat = 8'hA5; n_shift = 0; cap = 0;
        for (int b = 7; b >= 0; b--) begin
            h_din = pat[b]; h_sck = 0; run(3);
            h_sck = 1; run(3);
        end
        h_sck = 0; run(4);
        chk(n_shift == 8, "R2 shift pulse count", n_shift, 8);
        chk(cap == 8'hA5, "R2 captured byte", cap, 8'hA5);

        // R3 immediate entry, R5 during pause, R4 immediate exit
        cur_req = "R3"; n_lr = 0;
        h_ctl = 0; run(4);
        chk(h_oe == 0, "R3 immediate pause entry", h_oe, 0);
        cur_req = "R5"; n_shift = 0;
        for (int k = 0; k < 3; k++) begin h_sck = 1; h_din = ~h_din; run(3); h_sck = 0; run(3); end
        chk(n_shift == 0, "R5 no shift while paused", n_shift, 0);
        cur_req = "R4";
        h_ctl = 1; run(4);
        chk(h_oe == 1, "R4 immediate pause exit", h_oe, 1);

        // R3 deferred entry
        cur_req = "R3";
        h_sck = 1; run(4);
        h_ctl = 0; run(6);
        chk(h_oe == 1, "R3 deferred entry still active", h_oe, 1);
        h_sck = 0; run(4);
        chk(h_oe == 0, "R3 deferred entry on sck low", h_oe, 0);
        // R4 deferred exit
        cur_req = "R4";
        h_sck = 1; run(4);
        h_ctl = 1; run(6);
        chk(h_oe == 0, "R4 deferred exit still paused", h_oe, 0);
        h_sck = 0; run(4);
        chk(h_oe == 1, "R4 deferred exit on sck low", h_oe, 1);
        chk(n_lr == 0, "R6 no logic_reset from pause entry/exit", n_lr, 0);

        // R6 pin low while deselected
        cur_req = "R6";
        h_cs = 1; run(4);
        h_ctl = 0; run(4);
        h_cs = 0; run(5);
        chk(h_oe == 1, "R6 pin low at selection does not pause", h_oe, 1);
        h_ctl = 1; run(4);

        // R7 deselect during pause
        cur_req = "R7";
        h_ctl = 0; run(5);
        n_lr = 0;
        h_cs = 1; run(5);
        chk(n_lr == 1, "R7 one logic_reset on deselect", n_lr, 1);
        h_cs = 0; run(5);
        chk(h_oe == 0, "R7 reselect refused while pin low", h_oe, 0);
        h_cs = 1; run(2); h_ctl = 1; run(4);
        h_cs = 0; run(4);
        chk(h_oe == 1, "R7 selection after release", h_oe, 1);

        // R8 active power
        cur_req = "R8";
        h_cs = 1; h_busy = 1; run(4);
        chk(h_ap == 1, "R8 busy keeps active", h_ap, 1);
        h_busy = 0; run(2);
        chk(h_ap == 0, "R8 standby when idle", h_ap, 0);

        // R9 reset build strobes and recovery
        cur_req = "R9"; rn_lr = 0; rn_lc = 0;
        r_ctl = 0; run(5);
        chk(rn_lr == 1, "R9 one logic_reset on pin fall", rn_lr, 1);
        r_ctl = 1; run(5);
        chk(rn_lc == 1, "R9 one lock_clear on pin rise", rn_lc, 1);
        run(REC + 2);
        r_cs = 0; run(4);
        chk(r_oe == 1, "R9 selected after recovery", r_oe, 1);

        // R10 chip select during refusal
        cur_req = "R10";
        r_cs = 1; r_ctl = 0; run(4);
        r_ctl = 1; run(2);
        r_cs = 0; run(REC + 8);
        chk(r_oe == 0, "R10 stays deselected after early select", r_oe, 0);
        r_cs = 1; run(3);
        r_cs = 0; run(4);
        chk(r_oe == 1, "R10 fresh select accepted", r_oe, 1);
        r_cs = 1; run(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule